// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block is a set of hardware locks that several processors on one chip share through a simple register bus. Each processor has its own bus port. It takes a lock by writing its identity to that lock's word. It then reads the word back: if the returned owner equals its identity, it holds the lock. To hand the lock back it writes zero. Writing a lock that another identity already holds changes nothing, so the read-back shows the rightful owner. No atomic read-modify-write is needed anywhere in software.

A one-bit mode field selects between the plain polled scheme (mode 0) and an event-recording scheme (mode 1). In mode 1 every successful release sets a per-lock pending flag. A keyed write clears all of these flags at once. Reads are combinational from the stored state. Writes take effect at the next rising clock edge.

Top module: `hsem_bank`

## Requirements
- R1: After reset every lock word reads 0 (free), the mode word reads 0 and the pending-flag word reads 0.
- R2: A write to a free lock whose data bits [3:0] are non-zero stores those four bits as owner. Data bits [31:4] are ignored. A later read of the lock returns the owner in bits [3:0] and zeros above, on any port.
- R3: A write with non-zero data bits [3:0] to a lock that is already held leaves the stored owner unchanged.
- R4: A write with data bits [3:0] equal to 0 frees the lock only when the port's sideband identity input equals the stored owner. Otherwise it is ignored.
- R5: When several ports write the same lock in one cycle, the requests that would take effect on their own are collected first. Among them, the one from the lowest-numbered port is applied and the rest are dropped.
- R6: Lock n is at byte offset 0x08 + 4*n (n = 0..31), the mode word is at 0x00 and the pending-flag word is at 0x90. In the mode word only bit 0 is stored. A read returns it in bit 0 and zeros above.
- R7: A read of any other offset, including a misaligned offset inside the lock range, returns 0. A write to such an offset changes no state.
- R8: A release that takes effect sets bit n of the pending-flag word (for lock n) only while mode bit 0 is 1. In mode 0 a release sets no flag.
- R9: A write to the pending-flag word whose data bits [15:0] are all ones clears every flag by the next cycle. Any other value written there has no effect.
- R10: A claim or release of one lock leaves every other lock's owner unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | NUM_PORTS | Write strobe per port |
| busAddr | input | NUM_PORTS*ADDR_W | Byte offset per port, port p in bits [p*ADDR_W +: ADDR_W] |
| busWrData | input | NUM_PORTS*DATA_W | Write data per port |
| busMasterId | input | NUM_PORTS*4 | Sideband identity of the master behind each port |
| busRdData | output | NUM_PORTS*DATA_W | Combinational read data per port for its current offset |

## Verification
The claim path is tried on a free lock, on a held lock, and with junk in the upper data bits. This separates real ownership from a plain register that stores the last write. Releases are sent from the owner and from a non-owner, with the zero identity paired with a non-zero upper data word, so an owner check and a full-word zero test give different results. Same-cycle writes from both ports cover two cases. In the first, both are claims on a free lock, which exposes the port priority. In the second, port 0 sends a claim that would be refused and port 1 sends a valid release, which tells arbitration among valid requests apart from arbitration among raw requests. Misaligned, past-the-end and gap offsets, plus the flag word written with a non-key value and then with the key in each mode, bound the address decode and the flag rules.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

  // Width of the owner identity field kept per lock.
  localparam int ID_W = 4;
  // Width of the lock index carried in a port's decoded selection.
  localparam int SEL_IDX_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SEM  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_FLAG = 2'd3
  } selKind_e;

  // What a port's current offset points at.
  typedef struct packed {
    selKind_e               kind;
    logic [SEL_IDX_W-1:0]   idx;
  } portSel_t;

  // Per-lock update strobes from control to datapath.
  typedef struct packed {
    logic            claim;
    logic            drop;
    logic [ID_W-1:0] newId;
  } semStrobe_t;

  // Strobes for the mode bit and the pending flags.
  typedef struct packed {
    logic ctrlWe;
    logic ctrlBit;
    logic flagClr;
  } regStrobe_t;

endpackage

// File: rtl/hsem_ctrl.sv
module hsem_ctrl
  import hsem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_SEMS  = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CTRL_OFF  = 'h00,
  parameter int SEM_BASE  = 'h08,
  parameter int FLAG_OFF  = 'h90,
  parameter int CLR_KEY   = 'hFFFF
) (
  input  logic [NUM_PORTS-1:0]             wrEn,
  input  logic [NUM_PORTS*ADDR_W-1:0]      addr,
  input  logic [NUM_PORTS*DATA_W-1:0]      wrData,
  input  logic [NUM_PORTS*ID_W-1:0]        masterId,
  input  logic [NUM_SEMS-1:0][ID_W-1:0]    ownerQ,
  output portSel_t [NUM_PORTS-1:0]         portSel,
  output semStrobe_t [NUM_SEMS-1:0]        semStb,
  output regStrobe_t                       regStb
);

  localparam int SEM_END = SEM_BASE + 4 * NUM_SEMS;

  // Only a handful of data bits matter to the decode.
  logic unusedData;
  assign unusedData = ^wrData;

  // Address decode, one per port.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    logic [ADDR_W-1:0] portAddr;
    logic [ADDR_W-1:0] semOff;
    portSel_t          selP;

    assign portAddr = addr[p*ADDR_W +: ADDR_W];
    assign semOff   = portAddr - ADDR_W'(SEM_BASE);

    always_comb begin
      selP.kind = SEL_NONE;
      selP.idx  = SEL_IDX_W'(semOff >> 2);
      if (portAddr == ADDR_W'(CTRL_OFF)) begin
        selP.kind = SEL_CTRL;
      end else if (portAddr == ADDR_W'(FLAG_OFF)) begin
        selP.kind = SEL_FLAG;
      end else if ((32'(portAddr) >= SEM_BASE) && (32'(portAddr) < SEM_END) &&
                   (portAddr[1:0] == 2'b00)) begin
        selP.kind = SEL_SEM;
      end
    end

    assign portSel[p] = selP;
  end

  // Per-lock arbitration: only requests that would succeed alone compete,
  // and the lowest port among them is applied (scan from high to low).
  always_comb begin
    semStb = '0;
    for (int i = 0; i < NUM_SEMS; i++) begin
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        logic [ID_W-1:0] reqId;
        reqId = wrData[p*DATA_W +: ID_W];
        if (wrEn[p] && portSel[p].kind == SEL_SEM &&
            portSel[p].idx == SEL_IDX_W'(i)) begin
          if (reqId != '0 && ownerQ[i] == '0) begin
            semStb[i].claim = 1'b1;
            semStb[i].drop  = 1'b0;
            semStb[i].newId = reqId;
          end else if (reqId == '0 && ownerQ[i] != '0 &&
                       ownerQ[i] == masterId[p*ID_W +: ID_W]) begin
            semStb[i].claim = 1'b0;
            semStb[i].drop  = 1'b1;
            semStb[i].newId = '0;
          end
        end
      end
    end
  end

  // Mode word (lowest port wins) and keyed clear of the flags (any port).
  always_comb begin
    regStb = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (wrEn[p] && portSel[p].kind == SEL_CTRL) begin
        regStb.ctrlWe  = 1'b1;
        regStb.ctrlBit = wrData[p*DATA_W];
      end
      if (wrEn[p] && portSel[p].kind == SEL_FLAG &&
          wrData[p*DATA_W +: 16] == 16'(CLR_KEY)) begin
        regStb.flagClr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hsem_datapath.sv
module hsem_datapath
  import hsem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_SEMS  = 32,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  portSel_t [NUM_PORTS-1:0]         portSel,
  input  semStrobe_t [NUM_SEMS-1:0]        semStb,
  input  regStrobe_t                       regStb,
  output logic [NUM_SEMS-1:0][ID_W-1:0]    ownerQ,
  output logic                             protoQ,
  output logic [NUM_SEMS-1:0]              flagQ,
  output logic [NUM_PORTS*DATA_W-1:0]      rdData
);

  logic [NUM_SEMS-1:0] flagSet;

  // Owner storage, one register per lock.
  for (genvar i = 0; i < NUM_SEMS; i++) begin : g_sem
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ownerQ[i] <= '0;
      end else if (semStb[i].claim) begin
        ownerQ[i] <= semStb[i].newId;
      end else if (semStb[i].drop) begin
        ownerQ[i] <= '0;
      end
    end
    assign flagSet[i] = semStb[i].drop & protoQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protoQ <= 1'b0;
      flagQ  <= '0;
    end else begin
      if (regStb.ctrlWe) begin
        protoQ <= regStb.ctrlBit;
      end
      if (regStb.flagClr) begin
        flagQ <= '0;
      end else begin
        flagQ <= flagQ | flagSet;
      end
    end
  end

  // Read return, one multiplexer per port.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] rdP;
    always_comb begin
      rdP = '0;
      case (portSel[p].kind)
        SEL_CTRL: rdP = DATA_W'(protoQ);
        SEL_FLAG: rdP = DATA_W'(flagQ);
        SEL_SEM: begin
          for (int i = 0; i < NUM_SEMS; i++) begin
            if (portSel[p].idx == SEL_IDX_W'(i)) begin
              rdP = DATA_W'(ownerQ[i]);
            end
          end
        end
        default: rdP = '0;
      endcase
    end
    assign rdData[p*DATA_W +: DATA_W] = rdP;
  end

endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_SEMS  = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS-1:0]          busWrEn,
  input  logic [NUM_PORTS*ADDR_W-1:0]   busAddr,
  input  logic [NUM_PORTS*DATA_W-1:0]   busWrData,
  input  logic [NUM_PORTS*4-1:0]        busMasterId,
  output logic [NUM_PORTS*DATA_W-1:0]   busRdData
);

  portSel_t [NUM_PORTS-1:0]      portSel;
  semStrobe_t [NUM_SEMS-1:0]     semStb;
  regStrobe_t                    regStb;
  logic [NUM_SEMS-1:0][ID_W-1:0] semOwner;
  logic                          protoBit;
  logic [NUM_SEMS-1:0]           flagBits;

  hsem_ctrl #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_SEMS  (NUM_SEMS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_ctrl (
    .wrEn     (busWrEn),
    .addr     (busAddr),
    .wrData   (busWrData),
    .masterId (busMasterId),
    .ownerQ   (semOwner),
    .portSel  (portSel),
    .semStb   (semStb),
    .regStb   (regStb)
  );

  hsem_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_SEMS  (NUM_SEMS),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .portSel (portSel),
    .semStb  (semStb),
    .regStb  (regStb),
    .ownerQ  (semOwner),
    .protoQ  (protoBit),
    .flagQ   (flagBits),
    .rdData  (busRdData)
  );

endmodule

// File: rtl/hsem_bank_checker.sv
module hsem_bank_checker #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_SEMS  = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_PORTS-1:0]          busWrEn,
  input logic [NUM_PORTS*ADDR_W-1:0]   busAddr,
  input logic [NUM_PORTS*DATA_W-1:0]   busWrData,
  input logic [NUM_PORTS*4-1:0]        busMasterId,
  input logic [NUM_PORTS*DATA_W-1:0]   busRdData,
  input logic [NUM_SEMS-1:0][3:0]      ownerQ,
  input logic                          protoBit,
  input logic [NUM_SEMS-1:0]           flagBits
);

  logic [NUM_SEMS-1:0]  anyHit;
  logic [NUM_SEMS-1:0]  ownerZeroWrite;
  logic [NUM_PORTS-1:0] offMap;
  logic                 keyWrite;

  always_comb begin
    anyHit         = '0;
    ownerZeroWrite = '0;
    offMap         = '0;
    keyWrite       = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic [ADDR_W-1:0] a;
      logic              mapped;
      a = busAddr[p*ADDR_W +: ADDR_W];
      mapped = (a == ADDR_W'(0)) || (a == ADDR_W'('h90));
      for (int i = 0; i < NUM_SEMS; i++) begin
        if (a == ADDR_W'(8 + 4 * i)) begin
          mapped = 1'b1;
          if (busWrEn[p]) begin
            anyHit[i] = 1'b1;
            if (busWrData[p*DATA_W +: 4] == 4'd0 &&
                busMasterId[p*4 +: 4] == ownerQ[i]) begin
              ownerZeroWrite[i] = 1'b1;
            end
          end
        end
      end
      offMap[p] = !mapped;
      if (busWrEn[p] && a == ADDR_W'('h90) &&
          busWrData[p*DATA_W +: 16] == 16'hFFFF) begin
        keyWrite = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_SEMS; i++) begin : g_semChk
    // R2 / R10: an owner only moves when its own word was written
    a_r2_change_needs_write: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(ownerQ[i]) |-> $past(anyHit[i]));

    a_r3_held_no_steal: assert property (@(posedge clk) disable iff (!rstN)
      ($past(ownerQ[i]) != 4'd0) |->
        (ownerQ[i] == $past(ownerQ[i]) || ownerQ[i] == 4'd0));

    a_r4_free_by_owner: assert property (@(posedge clk) disable iff (!rstN)
      ($past(ownerQ[i]) != 4'd0 && ownerQ[i] == 4'd0) |-> $past(ownerZeroWrite[i]));

    a_r8_flag_needs_mode: assert property (@(posedge clk) disable iff (!rstN)
      (flagBits[i] && !$past(flagBits[i])) |-> $past(protoBit));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portChk
    a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
      offMap[p] |-> (busRdData[p*DATA_W +: DATA_W] == '0));
  end

  a_r9_key_clears_flags: assert property (@(posedge clk) disable iff (!rstN)
    $past(keyWrite) |-> (flagBits == '0));

endmodule

bind hsem_bank hsem_bank_checker #(
  .NUM_PORTS (NUM_PORTS),
  .NUM_SEMS  (NUM_SEMS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busWrEn     (busWrEn),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .busMasterId (busMasterId),
  .busRdData   (busRdData),
  .ownerQ      (semOwner),
  .protoBit    (protoBit),
  .flagBits    (flagBits)
);

// File: tb/hsem_bank_test.sv
`timescale 1ns/1ps
module hsem_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busWrEn = '0;
  logic [15:0] busAddr = '0;
  logic [63:0] busWrData = '0;
  logic [7:0]  busMasterId = '0;
  logic [63:0] busRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int          port;
    logic [31:0] exp;
    string       tag;
  } sbItem_t;

  sbItem_t sb[$];

  always #4 clk = ~clk;

  hsem_bank uut (
    .clk         (clk),
    .rstN        (rstN),
    .busWrEn     (busWrEn),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busMasterId (busMasterId),
    .busRdData   (busRdData)
  );

  // Monitor: compares queued expectations with the read port each negedge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        sbItem_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = busRdData[it.port*32 +: 32];
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s port %0d actual %h expected %h", it.tag, it.port, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] mid);
    @(posedge clk); #1;
    busWrEn[p] = 1'b1;
    busAddr[p*8 +: 8] = a;
    busWrData[p*32 +: 32] = d;
    busMasterId[p*4 +: 4] = mid;
    @(posedge clk); #1;
    busWrEn[p] = 1'b0;
  endtask

  task automatic wr2(input logic [7:0] a0, input logic [31:0] d0, input logic [3:0] m0,
                     input logic [7:0] a1, input logic [31:0] d1, input logic [3:0] m1);
    @(posedge clk); #1;
    busWrEn = 2'b11;
    busAddr = {a1, a0};
    busWrData = {d1, d0};
    busMasterId = {m1, m0};
    @(posedge clk); #1;
    busWrEn = 2'b00;
  endtask

  task automatic rd(input int p, input logic [7:0] a, input logic [31:0] e,
                    input string tag);
    sbItem_t it;
    @(posedge clk); #1;
    busAddr[p*8 +: 8] = a;
    it.port = p;
    it.exp  = e;
    it.tag  = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    rd(0, 8'h08, 32'h0, "R1 lock0 after reset");
    rd(1, 8'h84, 32'h0, "R1 lock31 after reset");
    rd(0, 8'h00, 32'h0, "R1 mode after reset");
    rd(1, 8'h90, 32'h0, "R1 flags after reset");

    // R2: claim of a free lock, upper data ignored
    wr(0, 8'h08, 32'hABCDE123, 4'd3);
    rd(0, 8'h08, 32'h3, "R2 claim read");
    rd(1, 8'h08, 32'h3, "R2 claim other port");
    rd(0, 8'h0C, 32'h0, "R10 neighbour untouched");

    // R3: claim of a held lock ignored
    wr(1, 8'h08, 32'h5, 4'd5);
    rd(1, 8'h08, 32'h3, "R3 held lock kept");

    // R4: release only by owner
    wr(1, 8'h08, 32'hFFFFFFF0, 4'd5);
    rd(0, 8'h08, 32'h3, "R4 non-owner release ignored");
    wr(0, 8'h08, 32'h0, 4'd3);
    rd(0, 8'h08, 32'h0, "R4 owner release");
    rd(1, 8'h90, 32'h0, "R8 no flag in mode 0");

    // R5: same-cycle contention
    wr2(8'h0C, 32'h2, 4'd2, 8'h0C, 32'h7, 4'd7);
    rd(1, 8'h0C, 32'h2, "R5 lowest port claim wins");
    wr2(8'h0C, 32'h9, 4'd9, 8'h0C, 32'h0, 4'd2);
    rd(0, 8'h0C, 32'h0, "R5 valid release beats refused claim");

    // R10: two locks in one cycle
    wr2(8'h10, 32'h6, 4'd6, 8'h14, 32'h8, 4'd8);
    rd(0, 8'h10, 32'h6, "R10 lock2 owner");
    rd(1, 8'h14, 32'h8, "R10 lock3 owner");

    // R6: last lock address
    wr(0, 8'h84, 32'hF, 4'hF);
    rd(0, 8'h84, 32'hF, "R6 lock31 at 0x84");

    // R7: unmapped offsets
    rd(0, 8'h85, 32'h0, "R7 misaligned read");
    wr(1, 8'h0E, 32'h4, 4'd4);
    rd(0, 8'h0C, 32'h0, "R7 misaligned write no effect");
    wr(0, 8'h88, 32'h1, 4'd1);
    rd(1, 8'h88, 32'h0, "R7 past-end read");
    rd(0, 8'h04, 32'h0, "R7 gap read");
    rd(1, 8'h84, 32'hF, "R7 lock31 intact");

    // R6: mode word keeps bit 0 only
    wr(0, 8'h00, 32'hFFFFFFFF, 4'd0);
    rd(0, 8'h00, 32'h1, "R6 mode bit0 only");

    // R8: flags in mode 1
    wr(1, 8'h84, 32'h0, 4'd1);
    rd(0, 8'h90, 32'h0, "R8 refused release sets no flag");
    wr(0, 8'h84, 32'h0, 4'hF);
    rd(0, 8'h90, 32'h80000000, "R8 flag for lock31");
    wr(1, 8'h10, 32'h0, 4'd6);
    rd(1, 8'h90, 32'h80000004, "R8 flag for lock2");
    rd(0, 8'h10, 32'h0, "R4 lock2 freed");

    // R9: keyed clear
    wr(0, 8'h90, 32'h1234, 4'd0);
    rd(0, 8'h90, 32'h80000004, "R9 non-key write ignored");
    wr(1, 8'h90, 32'hFFFF, 4'd0);
    rd(0, 8'h90, 32'h0, "R9 key clears all");

    // R8: back to mode 0, release records nothing
    wr(0, 8'h00, 32'h0, 4'd0);
    rd(1, 8'h00, 32'h0, "R6 mode cleared");
    wr(0, 8'h08, 32'h1, 4'd1);
    wr(0, 8'h08, 32'h0, 4'd1);
    rd(0, 8'h08, 32'h0, "R4 release in mode 0");
    rd(1, 8'h90, 32'h0, "R8 mode 0 no flag");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule